// File: doc/BRIEF.md
# Scan Test Sequencer

This controller applies a fixed list of combinational test vectors to a circuit that has one scan chain. Each vector has a primary-input word and a present-state word. The chain is loaded serially with test control low. The circuit then gets a single capture clock with test control high, and on that clock the primary inputs are driven and the primary outputs are judged. The captured next state leaves the chain on the serial output while the following vector's state enters it, so the unload of one vector costs no extra cycles.

A start pulse begins a run. The run opens with a chain integrity flush: a repeating 0,0,1,1 stream is shifted for chain-length-plus-four clocks and the returning stream is checked. The vectors come next, and a final shift-only pass unloads the last captured state. The stimulus and the expected responses are parameters of the block. Any mismatch sets a sticky fail flag. At the end of the run, done is raised together with a pass/fail verdict.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, done_o, fail_o, pass_o, scan_en_o and scan_in_o are all 0.
- R2: The first cycle after an accepted start opens a flush of CHAIN_LEN+4 cycles. During the flush scan_en_o is 0 and scan_in_o in flush cycle k (k from 0) equals bit 1 of k, giving the stream 0,0,1,1,0,0,...
- R3: In flush cycle k, scan_out_i is compared with bit 1 of (k-CHAIN_LEN) only when k is CHAIN_LEN or greater. Earlier flush cycles are not judged.
- R4: Vector v occupies bits [v*W +: W] of the matching parameter. Each vector gets CHAIN_LEN shift cycles with scan_en_o=0 and scan_in_o carrying the present state most significant bit first. One capture cycle follows with scan_en_o=1 and pi_o equal to the vector's input word. Outside capture, pi_o is 0.
- R5: po_i is compared with the vector's expected output word only in the capture cycle. In every other cycle its value is ignored.
- R6: In the shift cycles of vector v (v of 1 or more), scan_out_i is compared with the expected next state of vector v-1, most significant bit first. scan_out_i is ignored during the first vector's load and during capture cycles.
- R7: After the last capture, CHAIN_LEN unload cycles with scan_en_o=0 compare scan_out_i against the last vector's expected next state, most significant bit first.
- R8: done_o first reads 1 exactly CHAIN_LEN+4 + (CHAIN_LEN+1)*NUM_VEC + CHAIN_LEN cycles after the start is accepted. It stays 1 until the next accepted start.
- R9: fail_o is sticky for the whole run. pass_o equals done_o with fail_o low. A start is accepted only when idle or done, where it clears fail_o. A start during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with no mismatch |
| fail_o | output | 1 | Sticky mismatch flag |
| scan_en_o | output | 1 | Test control: 1 for capture, 0 for shift |
| scan_in_o | output | 1 | Serial data into the chain |
| scan_out_i | input | 1 | Serial data from the chain end |
| pi_o | output | PI_W | Primary inputs to the circuit |
| po_i | input | PO_W | Primary outputs from the circuit |

## Verification
In every shift cycle after the first vector, the serial load of the next state and the serial judgement of the previous capture happen on the same clock, so a stimulus error and a response error can coincide. The bench keeps a behavioural chain with its own capture function. It inverts the observed serial output or the primary outputs in one chosen cycle, picked at random or aimed at a directed boundary such as the first load, the flush edge or the last capture. It then predicts from the cycle map alone whether that cycle is judged, and the verdict and the run length must agree.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_FLUSH, PH_SHIFT, PH_CAPT, PH_UNLOAD, PH_DONE
  } phase_t;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 3,
  parameter int unsigned NUM_VEC   = 4,
  localparam int unsigned CW = $clog2(CHAIN_LEN + 4),
  localparam int unsigned VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output phase_t        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic [VW-1:0] vec_o,
  output logic          clr_o
);
  localparam logic [CW-1:0] FLUSH_LAST = CW'(CHAIN_LEN + 3);
  localparam logic [CW-1:0] SHIFT_LAST = CW'(CHAIN_LEN - 1);
  localparam logic [VW-1:0] VEC_LAST   = VW'(NUM_VEC - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic [VW-1:0] vec_q;

  assign clr_o   = start_i && (phase_q == PH_IDLE || phase_q == PH_DONE);
  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign vec_o   = vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      vec_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE, PH_DONE: begin
          if (start_i) begin
            phase_q <= PH_FLUSH;
            cnt_q   <= '0;
            vec_q   <= '0;
          end
        end
        PH_FLUSH: begin
          if (cnt_q == FLUSH_LAST) begin
            phase_q <= PH_SHIFT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SHIFT: begin
          if (cnt_q == SHIFT_LAST) begin
            phase_q <= PH_CAPT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CAPT: begin
          cnt_q <= '0;
          if (vec_q == VEC_LAST) begin
            phase_q <= PH_UNLOAD;
          end else begin
            phase_q <= PH_SHIFT;
            vec_q   <= vec_q + 1'b1;
          end
        end
        PH_UNLOAD: begin
          if (cnt_q == SHIFT_LAST) begin
            phase_q <= PH_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_seq_table.sv
module scan_seq_table #(
  parameter int unsigned CHAIN_LEN = 3,
  parameter int unsigned NUM_VEC   = 4,
  parameter int unsigned PI_W      = 3,
  parameter int unsigned PO_W      = 2,
  parameter logic [NUM_VEC*PI_W-1:0]      VEC_PI = '0,
  parameter logic [NUM_VEC*CHAIN_LEN-1:0] VEC_PS = '0,
  parameter logic [NUM_VEC*PO_W-1:0]      EXP_PO = '0,
  parameter logic [NUM_VEC*CHAIN_LEN-1:0] EXP_NS = '0,
  localparam int unsigned VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int unsigned SW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic [VW-1:0]   vec_i,
  input  logic [SW-1:0]   sel_i,
  output logic [PI_W-1:0] pi_o,
  output logic            ps_bit_o,
  output logic [PO_W-1:0] exp_po_o,
  output logic            prev_ns_bit_o,
  output logic            last_ns_bit_o
);
  logic [PI_W-1:0]      pi_a [NUM_VEC];
  logic [PO_W-1:0]      po_a [NUM_VEC];
  logic [CHAIN_LEN-1:0] ps_a [NUM_VEC];
  logic [CHAIN_LEN-1:0] ns_a [NUM_VEC];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_unpack
    assign pi_a[v] = VEC_PI[v*PI_W +: PI_W];
    assign po_a[v] = EXP_PO[v*PO_W +: PO_W];
    assign ps_a[v] = VEC_PS[v*CHAIN_LEN +: CHAIN_LEN];
    assign ns_a[v] = EXP_NS[v*CHAIN_LEN +: CHAIN_LEN];
  end

  logic [VW-1:0] prev_idx;
  assign prev_idx = (vec_i == '0) ? '0 : vec_i - 1'b1;

  logic [CHAIN_LEN-1:0] ps_w, prev_w, last_w;
  assign ps_w   = ps_a[vec_i];
  assign prev_w = ns_a[prev_idx];
  assign last_w = ns_a[NUM_VEC-1];

  assign pi_o          = pi_a[vec_i];
  assign exp_po_o      = po_a[vec_i];
  assign ps_bit_o      = ps_w[sel_i];
  assign prev_ns_bit_o = prev_w[sel_i];
  assign last_ns_bit_o = last_w[sel_i];
endmodule

// File: rtl/scan_seq_judge.sv
module scan_seq_judge #(
  parameter int unsigned PO_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            chk_so_i,
  input  logic            exp_so_i,
  input  logic            so_i,
  input  logic            chk_po_i,
  input  logic [PO_W-1:0] exp_po_i,
  input  logic [PO_W-1:0] po_i,
  output logic            fail_o
);
  logic miss;
  assign miss = (chk_so_i && (so_i != exp_so_i)) ||
                (chk_po_i && (po_i != exp_po_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fail_o <= 1'b0;
    else if (clr_i) fail_o <= 1'b0;
    else if (miss)  fail_o <= 1'b1;
  end
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 3,
  parameter int unsigned NUM_VEC   = 4,
  parameter int unsigned PI_W      = 3,
  parameter int unsigned PO_W      = 2,
  parameter logic [NUM_VEC*PI_W-1:0]      VEC_PI = 12'h5B2,
  parameter logic [NUM_VEC*CHAIN_LEN-1:0] VEC_PS = 12'hA63,
  parameter logic [NUM_VEC*PO_W-1:0]      EXP_PO = 8'h9C,
  parameter logic [NUM_VEC*CHAIN_LEN-1:0] EXP_NS = 12'h3D4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            done_o,
  output logic            pass_o,
  output logic            fail_o,
  output logic            scan_en_o,
  output logic            scan_in_o,
  input  logic            scan_out_i,
  output logic [PI_W-1:0] pi_o,
  input  logic [PO_W-1:0] po_i
);
  localparam int unsigned CW = $clog2(CHAIN_LEN + 4);
  localparam int unsigned VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int unsigned SW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CW-1:0] CL = CW'(CHAIN_LEN);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [VW-1:0] vec;
  logic          clr;

  scan_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .phase_o(phase), .cnt_o(cnt), .vec_o(vec), .clr_o(clr)
  );

  logic [SW-1:0]   sel;
  logic [PI_W-1:0] pi_val;
  logic [PO_W-1:0] exp_po;
  logic            ps_bit, prev_ns_bit, last_ns_bit;

  // shift position counts up, chain bit counts down (MSB leaves first)
  assign sel = SW'(CHAIN_LEN - 1) - SW'(cnt);

  scan_seq_table #(
    .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC), .PI_W(PI_W), .PO_W(PO_W),
    .VEC_PI(VEC_PI), .VEC_PS(VEC_PS), .EXP_PO(EXP_PO), .EXP_NS(EXP_NS)
  ) u_table (
    .vec_i(vec), .sel_i(sel), .pi_o(pi_val), .ps_bit_o(ps_bit),
    .exp_po_o(exp_po), .prev_ns_bit_o(prev_ns_bit), .last_ns_bit_o(last_ns_bit)
  );

  logic [CW-1:0] flush_ofs;
  logic          chk_so, exp_so, chk_po;
  assign flush_ofs = cnt - CL;

  always_comb begin
    scan_in_o = 1'b0;
    chk_so    = 1'b0;
    exp_so    = 1'b0;
    unique case (phase)
      PH_FLUSH: begin
        scan_in_o = cnt[1];
        chk_so    = (cnt >= CL);
        exp_so    = flush_ofs[1];
      end
      PH_SHIFT: begin
        scan_in_o = ps_bit;
        chk_so    = (vec != '0);
        exp_so    = prev_ns_bit;
      end
      PH_UNLOAD: begin
        chk_so = 1'b1;
        exp_so = last_ns_bit;
      end
      default: ;
    endcase
  end

  assign chk_po    = (phase == PH_CAPT);
  assign scan_en_o = chk_po;
  assign pi_o      = chk_po ? pi_val : '0;

  scan_seq_judge #(.PO_W(PO_W)) u_judge (
    .clk_i, .rst_ni, .clr_i(clr),
    .chk_so_i(chk_so), .exp_so_i(exp_so), .so_i(scan_out_i),
    .chk_po_i(chk_po), .exp_po_i(exp_po), .po_i(po_i),
    .fail_o(fail_o)
  );

  assign done_o = (phase == PH_DONE);
  assign pass_o = done_o && !fail_o;
endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic done_o,
  input logic pass_o,
  input logic fail_o,
  input logic scan_en_o
);
  a_r8_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r9_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);

  a_r9_pass_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o && !fail_o);

  a_r4_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |=> !scan_en_o);

  a_r2_restart_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> !done_o && !scan_en_o && !fail_o);

  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !scan_en_o);
endmodule

bind scan_test_seq scan_test_seq_chk u_chk (
  .clk_i, .rst_ni, .start_i, .done_o, .pass_o, .fail_o, .scan_en_o
);

// File: tb/scan_test_seq_test.sv
`timescale 1ns/1ps
module scan_test_seq_test;
  localparam int NS = 5;
  localparam int NC = 6;
  localparam int PW = 3;
  localparam int OW = 2;
  localparam int T  = NS + 4 + (NS + 1) * NC + NS;
  localparam logic [NC*PW-1:0] TB_PI = 18'h2D6B3;
  localparam logic [NC*NS-1:0] TB_PS = 30'h1B5C3E91;

  function automatic logic [NS-1:0] cut_next(logic [PW-1:0] p, logic [NS-1:0] s);
    return {s[NS-2:0], s[NS-1]} ^ NS'({p, p[1:0]});
  endfunction
  function automatic logic [OW-1:0] cut_po(logic [PW-1:0] p, logic [NS-1:0] s);
    return {(^s) ^ p[0], (s[0] & p[2]) | s[NS-1]};
  endfunction
  function automatic logic [NC*OW-1:0] build_po();
    logic [NC*OW-1:0] r = '0;
    for (int v = 0; v < NC; v++) r[v*OW +: OW] = cut_po(TB_PI[v*PW +: PW], TB_PS[v*NS +: NS]);
    return r;
  endfunction
  function automatic logic [NC*NS-1:0] build_ns();
    logic [NC*NS-1:0] r = '0;
    for (int v = 0; v < NC; v++) r[v*NS +: NS] = cut_next(TB_PI[v*PW +: PW], TB_PS[v*NS +: NS]);
    return r;
  endfunction
  localparam logic [NC*OW-1:0] TB_PO = build_po();
  localparam logic [NC*NS-1:0] TB_NS = build_ns();

  logic clk_i = 0, rst_ni = 0, start_i = 0;
  logic done_o, pass_o, fail_o, scan_en_o, scan_in_o, scan_out_i;
  logic [PW-1:0] pi_o;
  logic [OW-1:0] po_i;
  always #4 clk_i = ~clk_i;

  scan_test_seq #(.CHAIN_LEN(NS), .NUM_VEC(NC), .PI_W(PW), .PO_W(OW),
    .VEC_PI(TB_PI), .VEC_PS(TB_PS), .EXP_PO(TB_PO), .EXP_NS(TB_NS)) uut (.*);

  // behavioural circuit under test with fault injection
  int cyc = -1, inj_kind = 0, inj_cyc = -1;  // kind 1: so, 2: po, 3: capture
  logic [NS-1:0] chain = NS'(5'h13);
  assign scan_out_i = chain[NS-1] ^ (inj_kind == 1 && cyc == inj_cyc);
  assign po_i = cut_po(pi_o, chain) ^ OW'(inj_kind == 2 && cyc == inj_cyc);
  always @(posedge clk_i) begin
    if (scan_en_o) chain <= cut_next(pi_o, chain) ^ NS'(inj_kind == 3 && cyc == inj_cyc);
    else           chain <= {chain[NS-2:0], scan_in_o};
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic log_tc [64];
  logic log_si [64];
  logic [PW-1:0] log_pi [64];

  task automatic run(input int mid_start, output int len);
    @(negedge clk_i) start_i = 1;
    @(posedge clk_i); #1 start_i = 0;
    len = -1;
    for (int t = 0; t < 400; t++) begin
      cyc = t;
      start_i = (t == mid_start);
      @(negedge clk_i);
      if (done_o) begin len = t; break; end
      if (t < 64) begin log_tc[t] = scan_en_o; log_si[t] = scan_in_o; log_pi[t] = pi_o; end
      @(posedge clk_i); #1;
    end
    start_i = 0;
    cyc = -1;
  endtask

  function automatic bit so_judged(int c);
    int u;
    if (c < NS + 4) return c >= NS;
    u = c - (NS + 4);
    if (u < (NS + 1) * NC) return (u % (NS + 1) < NS) && (u / (NS + 1) > 0);
    return 1;
  endfunction
  function automatic bit is_capture(int c);
    int u = c - (NS + 4);
    return c >= NS + 4 && u < (NS + 1) * NC && (u % (NS + 1) == NS);
  endfunction

  task automatic fault_run(int kind, int at, bit exp_fail, string req);
    int len;
    inj_kind = kind; inj_cyc = at;
    run(-1, len);
    inj_kind = 0;
    chk(len == T, req, len, T);
    chk(fail_o == exp_fail && pass_o == !exp_fail, req, fail_o, exp_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int len, m_fl, m_sh, m_tc, m_pi, u, v, j, c, k;
    void'($urandom(32'd2718));
    #20 rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(!done_o && !fail_o && !pass_o, "R1 flags", {done_o, fail_o, pass_o}, 0);
    chk(!scan_en_o && !scan_in_o, "R1 scan pins", {scan_en_o, scan_in_o}, 0);

    // golden run
    run(-1, len);
    chk(len == T, "R8 run length", len, T);
    chk(pass_o && !fail_o, "R9 golden pass", pass_o, 1);
    m_fl = 0; m_sh = 0; m_tc = 0; m_pi = 0;
    for (int t = 0; t < T; t++) begin
      if (t < NS + 4) begin
        if (log_si[t] !== 1'((t >> 1) & 1)) m_fl++;
        if (log_tc[t] !== 1'b0) m_tc++;
      end else begin
        u = t - (NS + 4);
        if (u < (NS + 1) * NC) begin
          v = u / (NS + 1); j = u % (NS + 1);
          if (j < NS) begin
            if (log_si[t] !== TB_PS[v*NS + NS - 1 - j]) m_sh++;
            if (log_tc[t] !== 1'b0 || log_pi[t] !== '0) m_tc++;
          end else begin
            if (log_tc[t] !== 1'b1) m_tc++;
            if (log_pi[t] !== TB_PI[v*PW +: PW]) m_pi++;
          end
        end else if (log_tc[t] !== 1'b0) m_tc++;
      end
    end
    chk(m_fl == 0, "R2 flush stream", m_fl, 0);
    chk(m_sh == 0, "R4 load order msb first", m_sh, 0);
    chk(m_tc == 0, "R4 test control timing", m_tc, 0);
    chk(m_pi == 0, "R4 capture inputs", m_pi, 0);
    repeat (5) @(negedge clk_i);
    chk(done_o && pass_o, "R8 done held", done_o, 1);

    // directed corners
    fault_run(1, NS - 1, 0, "R3 early flush ignored");
    fault_run(1, NS + 1, 1, "R3 flush compared");
    fault_run(1, NS + 4, 0, "R6 first load ignored");
    fault_run(1, NS + 4 + NS, 0, "R6 capture so ignored");
    fault_run(1, NS + 4 + (NS + 1) + 1, 1, "R6 unload of vector 0");
    fault_run(2, NS + 4 + 3 * (NS + 1) - 1, 1, "R5 capture po compared");
    fault_run(2, NS + 4 + 2, 0, "R5 shift po ignored");
    fault_run(3, NS + 4 + (NS + 1) * NC - 1, 1, "R7 last unload");
    fault_run(1, T - 1, 1, "R7 final unload bit");
    // R9: restart clears fail, mid-run start ignored
    run(NS + 7, len);
    chk(len == T, "R9 mid-run start ignored", len, T);
    chk(pass_o && !fail_o, "R9 fail cleared by start", fail_o, 0);

    // random single-cycle faults
    for (int n = 0; n < 24; n++) begin
      k = ($urandom % 2) + 1;
      c = $urandom % T;
      fault_run(k, c, (k == 1) ? so_judged(c) : is_capture(c),
                (k == 1) ? "R6 random so fault" : "R5 random po fault");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule